// File: doc/BRIEF.md
# Shadow Nonvolatile Transfer Engine

This block holds a volatile byte array and a nonvolatile shadow array of the same size, and moves the whole contents between them. A save copies every volatile byte into the shadow. The shadow is first wiped to an erased value, and then each byte is programmed. A restore copies the shadow back into the volatile array. The volatile array is first cleared, and then each byte is loaded. A restore never touches the shadow.

Each phase walks the addresses upward from zero, one byte per clock. After both walks the engine waits until a programmable cycle count for that transfer kind has run out. There are three transfer kinds, each with its own duration parameter:
- save
- fast restore, started by software
- slow restore, started at power-up

While a transfer runs, `busy` is high and the host port is locked out:
- host writes are dropped;
- host reads return no data and leave the output drive off.

When a transfer ends, `done` pulses for one clock in the same cycle that `busy` falls. The default depth is kept small. Set `ADDR_W` to 13 to get 8192-byte arrays.

Top module: `nv_shadow_xfer`

## Requirements
- R1: After reset, `busy`, `done` and `host_drive` are 0, and `host_rdata` is 0.
- R2: When idle, a host read (`host_en`=1, `host_we`=0) returns the addressed byte on `host_rdata` with `host_drive`=1 in the next cycle. A host write (`host_en`=1, `host_we`=1) stores `host_wdata` at `host_addr`. In any cycle with no read, `host_drive` is 0 and `host_rdata` is 0.
- R3: A save leaves every shadow byte equal to the volatile byte at the same address. Older shadow contents are lost.
- R4: A restore (fast or slow) leaves every volatile byte equal to the shadow byte. The shadow is not changed, so a repeated restore gives the same data.
- R5: A transfer accepted at a clock edge holds `busy` high for exactly T cycles. T is the duration parameter of its kind, raised to 2×depth if smaller.
- R6: While `busy` is high, host writes change nothing and host reads leave `host_drive` at 0.
- R7: Any start request that arrives while `busy` is high is ignored, and it changes neither the running transfer nor its length.
- R8: When several start requests arrive together while idle, save wins over slow restore, and slow restore wins over fast restore.
- R9: `done` is high for exactly one cycle at the end of each transfer. In that cycle `busy` is 0, and in the cycle before it `busy` was 1.
- R10: From the cycle after `done`, host reads and writes work again as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_req | input | 1 | Start a save (volatile to shadow) |
| recall_req | input | 1 | Start a fast restore (shadow to volatile) |
| restore_req | input | 1 | Start a slow, power-up restore |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, 0 when not driven |
| host_drive | output | 1 | Read data valid (output enable) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check the following on every cycle:
- the lockout of the read drive;
- the shape of the `done` pulse against `busy`;
- that a running transfer keeps its kind until it ends;
- that any request made while idle is accepted on the next edge, with the correct priority.

Only the bench scenarios can show the rest:
- that data really moves between the arrays, and that the shadow survives repeated restores;
- that writes made during a lockout are lost;
- that each transfer kind lasts exactly its cycle count.

They do this by comparing every output against a behavioural model on every clock.

// File: rtl/nv_shadow_xfer.sv
module nv_shadow_xfer #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STORE_CYC   = 1000,
  parameter int RECALL_CYC  = 600,
  parameter int RESTORE_CYC = 800,
  parameter logic [7:0] ERASED  = 8'hFF,
  parameter logic [7:0] CLEARED = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              restore_req,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_drive,
  output logic              busy,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MIN_T = 2 * DEPTH;
  localparam int ST_T  = (STORE_CYC   < MIN_T) ? MIN_T : STORE_CYC;
  localparam int RC_T  = (RECALL_CYC  < MIN_T) ? MIN_T : RECALL_CYC;
  localparam int RS_T  = (RESTORE_CYC < MIN_T) ? MIN_T : RESTORE_CYC;
  localparam int MAX_A = (ST_T > RC_T) ? ST_T : RC_T;
  localparam int MAX_T = (MAX_A > RS_T) ? MAX_A : RS_T;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] DEP_C  = CW'(DEPTH);
  localparam logic [CW-1:0] TWO_C  = CW'(MIN_T);
  localparam logic [CW-1:0] ST_L   = CW'(ST_T - 1);
  localparam logic [CW-1:0] RC_L   = CW'(RC_T - 1);
  localparam logic [CW-1:0] RS_L   = CW'(RS_T - 1);

  typedef enum logic [1:0] {K_SAVE, K_FAST, K_SLOW} kind_t;

  logic [DATA_W-1:0] vol [DEPTH];
  logic [DATA_W-1:0] shd [DEPTH];

  kind_t kind, pick;
  logic [CW-1:0] cnt, last;
  logic [ADDR_W-1:0] xaddr;
  logic start, wipe_ph, copy_ph;

  assign start   = !busy && (store_req || recall_req || restore_req);
  assign pick    = store_req ? K_SAVE : (restore_req ? K_SLOW : K_FAST);
  assign last    = (kind == K_SAVE) ? ST_L : ((kind == K_SLOW) ? RS_L : RC_L);
  assign wipe_ph = cnt < DEP_C;
  assign copy_ph = !wipe_ph && (cnt < TWO_C);
  assign xaddr   = cnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (busy) begin
      if (kind == K_SAVE) begin
        if (wipe_ph)      shd[xaddr] <= ERASED[DATA_W-1:0];
        else if (copy_ph) shd[xaddr] <= vol[xaddr];
      end else begin
        if (wipe_ph)      vol[xaddr] <= CLEARED[DATA_W-1:0];
        else if (copy_ph) vol[xaddr] <= shd[xaddr];
      end
    end else if (host_en && host_we) begin
      vol[host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      kind <= K_SAVE;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == last) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        kind <= pick;
        cnt  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      host_drive <= 1'b0;
    end else if (!busy && host_en && !host_we) begin
      host_rdata <= vol[host_addr];
      host_drive <= 1'b1;
    end else begin
      host_rdata <= '0;
      host_drive <= 1'b0;
    end
  end

  p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !host_drive);

  p_done_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_kind_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != last) |=> (busy && $stable(kind)));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (store_req || recall_req || restore_req)) |=> busy);

  p_save_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && store_req) |=> (kind == K_SAVE));

  p_slow_over_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !store_req && restore_req) |=> (kind == K_SLOW));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= last));
endmodule

// File: tb/test_nv_shadow_xfer.sv
module test_nv_shadow_xfer;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam int ST = 100, RC = 70, RS = 90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic store_req = 0, recall_req = 0, restore_req = 0;
  logic host_en = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic host_drive, busy, done;

  int checks = 0, errors = 0;
  bit started = 0;

  always #10 clk = ~clk;

  nv_shadow_xfer #(.ADDR_W(AW), .DATA_W(8), .STORE_CYC(ST), .RECALL_CYC(RC),
                   .RESTORE_CYC(RS)) i_nv_shadow_xfer (
    .clk(clk), .rst_n(rst_n), .store_req(store_req), .recall_req(recall_req),
    .restore_req(restore_req), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_drive(host_drive), .busy(busy), .done(done));

  // behavioural reference
  logic [7:0] mvol [DEPTH];
  logic [7:0] mshd [DEPTH];
  logic mbusy = 0, mdone = 0, mdrive = 0;
  logic [7:0] mrdata = 0;
  int mrem = 0, mkind = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mdone = 0; mdrive = 0; mrdata = 0; mrem = 0;
      started = 1;
    end else begin
      automatic logic pb = mbusy;
      mdone = 0;
      if (pb) begin
        mrem--;
        if (mrem == 0) begin
          mbusy = 0; mdone = 1;
          for (int a = 0; a < DEPTH; a++)
            if (mkind == 0) mshd[a] = mvol[a]; else mvol[a] = mshd[a];
        end
      end else if (store_req) begin mkind = 0; mrem = ST; mbusy = 1; end
      else if (restore_req) begin mkind = 2; mrem = RS; mbusy = 1; end
      else if (recall_req)  begin mkind = 1; mrem = RC; mbusy = 1; end
      if (!pb && host_en && !host_we) begin
        mdrive = 1; mrdata = mvol[host_addr];
      end else begin
        mdrive = 0; mrdata = 0;
        if (!pb && host_en && host_we) mvol[host_addr] = host_wdata;
      end
    end
  end

  always @(negedge clk) if (started) begin
    check(busy === mbusy, "R5 busy", busy, mbusy);
    check(done === mdone, "R9 done", done, mdone);
    check(host_drive === mdrive, "R6 host_drive", host_drive, mdrive);
    check(host_rdata === mrdata, "R2/R3/R4 host_rdata", host_rdata, mrdata);
  end

  task automatic wr(input int a, input int d);
    host_en = 1; host_we = 1; host_addr = AW'(a); host_wdata = 8'(d);
    @(negedge clk); host_en = 0; host_we = 0;
  endtask

  task automatic rd(input int a);
    host_en = 1; host_we = 0; host_addr = AW'(a);
    @(negedge clk); host_en = 0;
  endtask

  // pulse requests, count busy cycles until done, poking the port meanwhile
  task automatic xfer(input bit s, input bit f, input bit w, input int len, input string tag);
    int n = 0;
    bit seen = 0;
    store_req = s; recall_req = f; restore_req = w;
    @(negedge clk); store_req = 0; recall_req = 0; restore_req = 0;
    while (!seen && n < 1000) begin
      if (busy) n++;
      if (n == 3) begin host_en = 1; host_we = 1; host_addr = 3; host_wdata = 8'hEE; end // R6 write lost
      else if (n == 4) begin host_en = 1; host_we = 0; host_addr = 3; end                // R6 read blocked
      else if (n == 5) begin host_en = 0; recall_req = 1; store_req = 1; end            // R7 ignored
      else begin host_en = 0; recall_req = 0; store_req = 0; end
      @(negedge clk);
      if (done) begin
        seen = 1;
        check(busy == 0, {tag, " R9 busy low with done"}, busy, 0);
      end
    end
    host_en = 0; recall_req = 0; store_req = 0;
    check(seen, {tag, " R9 done seen"}, seen, 1);
    check(n == len, {tag, " R5 busy length"}, n, len);
    @(negedge clk);
    check(busy == 0 && done == 0, {tag, " R7 no restart after done"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && host_drive === 0 && host_rdata === 0,
          "R1 reset state", {busy, done, host_drive}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) wr(a, a * 7 + 3);             // R2
    for (int a = 0; a < DEPTH; a++) rd(a);
    xfer(1, 0, 0, ST, "save");                                    // R3 R6 R7
    for (int a = 0; a < DEPTH; a++) wr(a, 8'hA5 ^ a);             // R10
    for (int a = 0; a < 4; a++) rd(a);
    xfer(0, 1, 0, RC, "fast");                                    // R4
    for (int a = 0; a < DEPTH; a++) rd(a);
    wr(5, 8'h11);
    xfer(0, 1, 0, RC, "fast again");                              // R4 repeat
    for (int a = 0; a < DEPTH; a++) rd(a);
    for (int a = 0; a < DEPTH; a++) wr(a, 255 - a);
    xfer(0, 1, 1, RS, "slow over fast");                          // R8
    for (int a = 0; a < DEPTH; a++) rd(a);
    for (int a = 0; a < DEPTH; a++) wr(a, a);
    xfer(1, 1, 1, ST, "save over all");                           // R8
    for (int a = 0; a < DEPTH; a += 3) wr(a, 8'h5C);
    xfer(0, 0, 1, RS, "slow");                                    // R3 R4
    for (int a = 0; a < DEPTH; a++) rd(a);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule